// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs read and write cycles on an external asynchronous memory bus on behalf of a processor core. The core raises a request with an address, write data, a direction bit and a set of chip-select attribute bits. The block latches them and drives active-low read or write strobes with the attribute lines for the whole cycle. Once the cycle ends it hands back the read data with a one-clock done pulse.

The length of each cycle is set by two things. A programmed minimum wait count gives the shortest cycle. An active-low transfer-acknowledge input from the memory side can stretch it further. The cycle lasts for whichever of the two is longer, and it ends one clock after the acknowledge is seen. A mode input chooses whether the acknowledge is taken as synchronous (one capture flop) or asynchronous (a two-flop synchroniser). A cycle with a minimum of zero wait states never looks at the acknowledge.

Every strobe, attribute and write-data output has its own output-enable. These enables are low during hardware reset and while the core's low-power stop/wait mode is active.

Top module: `ext_bus_seq`

## Requirements
- R1: While `rst_n` is low, `strobe_oe`, `attr_oe`, `bus_dout_oe` and `done` are 0. After reset the block is idle: `rd_n` = `wr_n` = 1 and `rdata` = 0.
- R2: In a read cycle (`req_wr`=0), `rd_n` is 0, `wr_n` is 1 and `bus_dout_oe` is 0. In a write cycle (`req_wr`=1), `wr_n` is 0, `rd_n` is 1, `bus_dout_oe` is 1 and `bus_dout` equals the request's write data. Both strobes are 1 in the cycle where `done` is high.
- R3: In synchronous acknowledge mode (`ack_async`=0) with minimum wait W ≥ 1, the acknowledge (`xack_n` low) is first driven in strobe cycle D+1. The strobes then stay asserted for max(W+1, D+2) clock cycles.
- R4: While `xack_n` is held high, a cycle with W ≥ 1 does not end, even well past W+1 cycles.
- R5: With W = 0, the strobes are asserted for exactly one clock cycle, whatever the state of `xack_n`.
- R6: In asynchronous mode (`ack_async`=1) with W ≥ 1, under the same timing as R3, the strobes stay asserted for max(W+1, D+3) cycles.
- R7: `xack_n` has no effect while no cycle is in progress: `done` stays 0 and both strobes stay 1.
- R8: Attribute bit i is driven as `req_attr[i]` during a cycle and 0 when idle, then inverted when `attr_pol[i]` is 0. `attr_pol[i]`=1 means active-high and 0 means active-low.
- R9: While `lp_mode` is 1, `strobe_oe`, `attr_oe` and `bus_dout_oe` are 0 and no new request is accepted.
- R10: A request is accepted only when idle. `bus_addr`, `bus_dout` and the attribute lines stay at the accepted values for the whole cycle, even if the request inputs change.
- R11: `done` is high for exactly one clock cycle, in the cycle after the last strobe cycle. `rdata` then holds the value `bus_din` had on the last strobe cycle's final edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low hardware reset |
| lp_mode | input | 1 | Low-power stop/wait mode active |
| ack_async | input | 1 | 1: acknowledge passes through the two-flop synchroniser |
| min_wait | input | WW | Minimum wait states per cycle |
| attr_pol | input | NA | Per-bit attribute polarity (1 = active-high) |
| req | input | 1 | Core cycle request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| req_attr | input | NA | Chip-select attribute bits, 1 = select |
| done | output | 1 | One-clock cycle-complete pulse |
| rdata | output | DW | Captured read data |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | External write data |
| bus_dout_oe | output | 1 | Write-data output enable |
| bus_din | input | DW | External read data |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| strobe_oe | output | 1 | Output enable for both strobes |
| attr_out | output | NA | Attribute / chip-select lines |
| attr_oe | output | 1 | Attribute output enable |
| xack_n | input | 1 | Active-low transfer acknowledge |

## Verification
Most internal faults show up as a wrong strobe width, so the bench measures the number of strobe-low cycles of every cycle and compares it with the R3/R5/R6 formula. The sweep covers all wait counts 0..7 against acknowledge delays 0..10 in both modes. A miscounted wait counter or a wrong synchroniser depth shows up within the same cycle as a length off by one. A stale acknowledge capture left over from an idle period makes the next cycle too short, and a lost one makes it hang; the done-wait bound reports that within 200 clocks. Latch faults show up as a `bus_addr` change during the cycle or as `rdata` differing from the value of `bus_din` on the final edge.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
   typedef enum logic {
      CYC_IDLE = 1'b0,
      CYC_BUSY = 1'b1
   } cyc_state_e;
endpackage

// File: rtl/ebs_ack_sync.sv
module ebs_ack_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic async_mode,
   input  logic ack_n,
   output logic hit
);
   logic [SYNC_STAGES-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= 1'b0;
      else        stg_q[0] <= arm & ~ack_n;
   end

   for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[i] <= 1'b0;
         else        stg_q[i] <= arm & stg_q[i-1];
      end
   end

   assign hit = async_mode ? stg_q[SYNC_STAGES-1] : stg_q[0];

   // R7: acknowledge seen while not armed is dropped
   p_no_hit_unarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> !hit);
endmodule

// File: rtl/ebs_cycle_fsm.sv
module ebs_cycle_fsm
   import ebs_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 24,
   parameter int WW = 4,
   parameter int NA = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lp_mode,
   input  logic [WW-1:0] min_wait,
   input  logic          req,
   input  logic          req_wr,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [NA-1:0] req_attr,
   input  logic [DW-1:0] bus_din,
   input  logic          ack_hit,
   output logic          busy,
   output logic          arm,
   output logic          wr_q,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] wdata_q,
   output logic [NA-1:0] attr_q,
   output logic          done,
   output logic [DW-1:0] rdata
);
   cyc_state_e    st_q;
   logic [WW-1:0] lim_q;
   logic [WW-1:0] cnt_q;
   logic          accept;
   logic          cnt_met;
   logic          finish;

   always_comb begin
      busy    = (st_q == CYC_BUSY);
      accept  = (st_q == CYC_IDLE) && req && !lp_mode;
      cnt_met = (cnt_q >= lim_q);
      finish  = busy && cnt_met && ((lim_q == '0) || ack_hit);
      arm     = busy && !finish && (lim_q != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= CYC_IDLE;
         lim_q   <= '0;
         cnt_q   <= '0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         attr_q  <= '0;
         done    <= 1'b0;
         rdata   <= '0;
      end else begin
         done <= finish;
         if (accept) begin
            st_q    <= CYC_BUSY;
            lim_q   <= min_wait;
            cnt_q   <= '0;
            wr_q    <= req_wr;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            attr_q  <= req_attr;
         end else if (finish) begin
            st_q  <= CYC_IDLE;
            rdata <= bus_din;
         end else if (busy && !cnt_met) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_zero_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && lim_q == '0) |=> done);

   p_hold_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(addr_q) && $stable(wdata_q) && $stable(attr_q)));
endmodule

// File: rtl/ebs_pin_drv.sv
module ebs_pin_drv #(
   parameter int NA = 2
) (
   input  logic          rst_n,
   input  logic          lp_mode,
   input  logic          busy,
   input  logic          wr_q,
   input  logic [NA-1:0] attr_q,
   input  logic [NA-1:0] attr_pol,
   output logic          rd_n,
   output logic          wr_n,
   output logic          strobe_oe,
   output logic [NA-1:0] attr_out,
   output logic          attr_oe,
   output logic          dout_oe
);
   logic drive_ok;

   always_comb begin
      drive_ok  = rst_n && !lp_mode;
      rd_n      = !(busy && !wr_q);
      wr_n      = !(busy && wr_q);
      strobe_oe = drive_ok;
      attr_oe   = drive_ok;
      dout_oe   = drive_ok && busy && wr_q;
   end

   for (genvar i = 0; i < NA; i++) begin : g_attr
      logic sel;
      assign sel = busy && attr_q[i];
      if (1) begin : g_pol
         assign attr_out[i] = attr_pol[i] ? sel : !sel;
      end
   end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
   parameter int AW          = 16,
   parameter int DW          = 24,
   parameter int WW          = 4,
   parameter int NA          = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lp_mode,
   input  logic          ack_async,
   input  logic [WW-1:0] min_wait,
   input  logic [NA-1:0] attr_pol,
   input  logic          req,
   input  logic          req_wr,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [NA-1:0] req_attr,
   output logic          done,
   output logic [DW-1:0] rdata,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_dout,
   output logic          bus_dout_oe,
   input  logic [DW-1:0] bus_din,
   output logic          rd_n,
   output logic          wr_n,
   output logic          strobe_oe,
   output logic [NA-1:0] attr_out,
   output logic          attr_oe,
   input  logic          xack_n
);
   if (AW < 1 || DW < 1 || NA < 1) begin : g_bad_width
      $error("ext_bus_seq: AW, DW and NA must be positive");
   end
   if (WW < 1 || WW > 16) begin : g_bad_ww
      $error("ext_bus_seq: WW must be in 1..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ext_bus_seq: SYNC_STAGES must be at least 2");
   end

   logic          busy;
   logic          arm;
   logic          ack_hit;
   logic          wr_q;
   logic [NA-1:0] attr_q;

   ebs_ack_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (arm),
      .async_mode (ack_async),
      .ack_n      (xack_n),
      .hit        (ack_hit)
   );

   ebs_cycle_fsm #(.AW(AW), .DW(DW), .WW(WW), .NA(NA)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .lp_mode   (lp_mode),
      .min_wait  (min_wait),
      .req       (req),
      .req_wr    (req_wr),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_attr  (req_attr),
      .bus_din   (bus_din),
      .ack_hit   (ack_hit),
      .busy      (busy),
      .arm       (arm),
      .wr_q      (wr_q),
      .addr_q    (bus_addr),
      .wdata_q   (bus_dout),
      .attr_q    (attr_q),
      .done      (done),
      .rdata     (rdata)
   );

   ebs_pin_drv #(.NA(NA)) u_pins (
      .rst_n     (rst_n),
      .lp_mode   (lp_mode),
      .busy      (busy),
      .wr_q      (wr_q),
      .attr_q    (attr_q),
      .attr_pol  (attr_pol),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .strobe_oe (strobe_oe),
      .attr_out  (attr_out),
      .attr_oe   (attr_oe),
      .dout_oe   (bus_dout_oe)
   );

   p_done_strobes_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rd_n && wr_n));
endmodule

// File: tb/ext_bus_seq_test.sv
module ext_bus_seq_test;
   localparam int AW = 16, DW = 24, WW = 4, NA = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lp_mode = 1'b0, ack_async = 1'b0;
   logic [WW-1:0] min_wait = '0;
   logic [NA-1:0] attr_pol = '1;
   logic          req = 1'b0, req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [NA-1:0] req_attr = '0;
   logic          done;
   logic [DW-1:0] rdata;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_dout;
   logic          bus_dout_oe;
   logic [DW-1:0] bus_din = '0;
   logic          rd_n, wr_n, strobe_oe, attr_oe;
   logic [NA-1:0] attr_out;
   logic          xack_n = 1'b1;

   int n_chk = 0, n_fail = 0, n_clk = 0, run_id = 0;

   always #10 clk = ~clk;

   ext_bus_seq #(.AW(AW), .DW(DW), .WW(WW), .NA(NA)) uut (.*);

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic int exp_len(input int w, input int d, input int as);
      int t;
      if (w == 0) return 1;
      t = d + 2 + as;
      return (w + 1 > t) ? w + 1 : t;
   endfunction

   // One bus cycle: ack first driven in strobe cycle d+1; returns strobe-low count.
   task automatic run_cycle(input int w, input int d, input bit wr, input bit as,
                            input logic [NA-1:0] attr, input logic [NA-1:0] pol,
                            output int len);
      logic [AW-1:0] a0;
      logic [DW-1:0] wd0, base;
      bit addr_ok, seen_done;
      int c;
      run_id++;
      a0 = AW'(16'h1200 + run_id);
      wd0 = DW'(24'hA50000 + run_id);
      base = DW'(24'h300000 + (run_id << 8));
      @(negedge clk);
      min_wait = WW'(w); ack_async = as; attr_pol = pol;
      req = 1'b1; req_wr = wr; req_addr = a0; req_wdata = wd0; req_attr = attr;
      xack_n = 1'b1;
      len = 0; c = 0; addr_ok = 1'b1; seen_done = 1'b0;
      while (c < 200) begin
         @(negedge clk);
         c++;
         if (c == 1) req = 1'b0;
         if (done) begin seen_done = 1'b1; break; end
         if (!rd_n || !wr_n) len++;
         if (c == 1) begin
            check(rd_n == wr || wr_n == !wr ? (rd_n == wr && wr_n == !wr) : 1'b0,
                  "R2 strobe", {rd_n, wr_n}, {wr, !wr});
            check(bus_dout_oe == wr && (!wr || bus_dout == wd0), "R2 write data", bus_dout_oe, wr);
            check(attr_out == (attr ^ ~pol), "R8 attr busy", attr_out, attr ^ ~pol);
         end
         if (c == 2) begin
            req = 1'b1; req_addr = ~a0; req_wdata = ~wd0; req_attr = ~attr;
         end
         if (c == 3) req = 1'b0;
         if (bus_addr != a0 || (wr && bus_dout != wd0)) addr_ok = 1'b0;
         if (c - 1 >= d) xack_n = 1'b0;
         bus_din = base + DW'(c);
      end
      req = 1'b0; xack_n = 1'b1;
      check(seen_done, "R11 done seen", seen_done, 1);
      check(addr_ok, "R10 fields held", addr_ok, 1);
      check(rd_n && wr_n, "R2 strobes off at done", {rd_n, wr_n}, 3);
      check(rdata == base + DW'(len), "R11 rdata", rdata, base + DW'(len));
      @(negedge clk);
      check(!done, "R11 done single", done, 0);
      check(attr_out == ~pol, "R8 attr idle", attr_out, ~pol);
   endtask

   // {w, d, wr, async, expected strobe cycles}
   localparam int VEC[8][5] = '{
      '{0, 5, 0, 0, 1}, '{1, 0, 0, 0, 2}, '{3, 0, 1, 0, 4}, '{2, 6, 0, 0, 8},
      '{7, 3, 1, 0, 8}, '{4, 4, 0, 1, 7}, '{5, 9, 1, 1, 12}, '{1, 0, 0, 1, 3}
   };

   initial begin : watchdog
      while (n_clk < 150000) begin
         @(posedge clk);
         n_clk++;
      end
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", n_clk, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      int len;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!strobe_oe && !attr_oe && !bus_dout_oe && !done, "R1 reset oe",
            {strobe_oe, attr_oe, bus_dout_oe, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rd_n && wr_n && rdata == '0 && strobe_oe, "R1 idle after reset",
            {rd_n, wr_n, strobe_oe}, 7);

      // vector table
      foreach (VEC[i]) begin
         run_cycle(VEC[i][0], VEC[i][1], VEC[i][2] != 0, VEC[i][3] != 0, 2'b01, 2'b11, len);
         check(len == VEC[i][4], VEC[i][0] == 0 ? "R5 table" : (VEC[i][3] != 0 ? "R6 table" : "R3 table"),
               len, VEC[i][4]);
      end

      // sweep W 0..7, D 0..10, both acknowledge modes
      for (int as = 0; as < 2; as++)
         for (int w = 0; w < 8; w++)
            for (int d = 0; d <= 10; d++) begin
               run_cycle(w, d, d[0], as != 0, 2'b10, 2'b10, len);
               check(len == exp_len(w, d, as),
                     w == 0 ? "R5 sweep" : (as != 0 ? "R6 sweep" : "R3 sweep"),
                     len, exp_len(w, d, as));
            end

      // R4 long stretch
      run_cycle(3, 40, 1'b0, 1'b0, 2'b11, 2'b01, len);
      check(len == 42, "R4 stretch", len, 42);

      // R7 acknowledge while idle
      begin
         bit ok7;
         ok7 = 1'b1;
         @(negedge clk);
         xack_n = 1'b0;
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (done || !rd_n || !wr_n) ok7 = 1'b0;
         end
         check(ok7, "R7 idle ack ignored", ok7, 1);
         run_cycle(3, 2, 1'b0, 1'b0, 2'b01, 2'b11, len);
         check(len == 4, "R7 no stale ack", len, 4);
      end

      // R9 low-power mode
      begin
         bit ok9;
         ok9 = 1'b1;
         @(negedge clk);
         lp_mode = 1'b1; req = 1'b1; req_wr = 1'b1; min_wait = 4'd1;
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (strobe_oe || attr_oe || bus_dout_oe || done || !rd_n || !wr_n) ok9 = 1'b0;
         end
         req = 1'b0;
         @(negedge clk);
         lp_mode = 1'b0;
         @(negedge clk);
         check(ok9 && rd_n && wr_n && strobe_oe, "R9 low power", ok9, 1);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule